// File: doc/BRIEF.md
# Triggered Command Queue Scan Controller

This block is the control state machine for one command queue that feeds conversion commands to a serial converter link. It decides when the queue may put commands on the link and tracks how far through the queue it has got. It offers three ways to run a scan. In single-scan level mode, software arms the queue and an external gate level lets the scan run. In continuous software mode, the queue loops through its commands without stopping. In continuous edge mode, a chosen edge of the external trigger starts a pass through the queue.

Each command is handed to the link through a request/grant handshake. `xfer_en` is the request. A priority arbiter, which is not part of this block, answers with `arb_grant` when this queue is the highest-priority one whose target buffer has room. A command is issued in any cycle where both are high, and `tx_start` pulses in that cycle. The end-of-queue and pause markers of the head command are sampled in that same cycle. The link applies back-pressure by holding off `tx_done`. Only one command may be in flight, so `xfer_en` stays low until `tx_done` closes the transfer. The external trigger is asynchronous and passes through a synchronizer before any edge or level decision is made. Three sticky flags (pause, end-of-queue, trigger overrun) drive interrupt requests.

Top module: `cq_scan_ctrl`

## Requirements
- R1: Mode codes are 0 disabled, 1 single-scan level, 2 continuous software, 3 continuous rising edge, 4 continuous falling edge and 5 continuous either edge; codes 6 and 7 act as disabled. In disabled mode, at the next clock the status is IDLE (`q_status`=0), the transfer count is 0, `scan_armed` is 0, no transfer is outstanding and `xfer_en` is low.
- R2: `xfer_en` is high only while the status is TRIGGERED (`q_status`=1) and no command is in flight. A command issues (`tx_start`) in a cycle with `xfer_en` and `arb_grant` both high, and at most one is outstanding. The transfer count rises by one (modulo 2^CNT_W) at `tx_done`, and returns to 0 when the completed command carried the end-of-queue marker.
- R3: In single-scan level mode, the queue becomes TRIGGERED only when `scan_armed` is set (by a pulse on `scan_start_set`) and the synchronized trigger level is high (gate open).
- R4: In single-scan level mode, completing an end-of-queue command sets the end-of-queue flag, clears `scan_armed` and returns to IDLE. The pause marker has no effect in this mode.
- R5: In single-scan level mode, a gate that closes while no command is in flight sends the queue to IDLE at once, clears `scan_armed` and sets the pause flag. The count is kept, so a later restart (re-arm plus open gate) resumes from the same command.
- R6: In single-scan level mode, a gate that closes during a transfer leaves the status TRIGGERED until `tx_done`. If the gate is still closed then, the count is updated, `scan_armed` is cleared, the pause flag is set and the status becomes IDLE.
- R7: In single-scan level mode, a gate that closes and reopens within one transfer sets the overrun flag, leaves the pause flag and status unchanged, and lets transfers continue.
- R8: In continuous software mode, the queue becomes TRIGGERED without `scan_armed` and stays TRIGGERED. End-of-queue sets its flag and resets the count but does not halt. Pause markers are ignored.
- R9: In the continuous edge modes, the selected edge of the synchronized trigger moves IDLE to TRIGGERED, and edges that are not selected do nothing. Completing an end-of-queue command or a pause command halts the queue to IDLE and sets the matching flag. The next selected edge resumes transfers with the count kept.
- R10: In the continuous edge modes, a selected edge seen while already TRIGGERED sets the overrun flag.
- R11: `flags` and `irqs` use bit 0 for pause, bit 1 for end-of-queue and bit 2 for overrun. A flag stays set until its `flag_clr` bit is pulsed. `irqs[i]` is `flags[i]` AND `irq_en[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operating mode code (see R1) |
| scan_start_set | input | 1 | Pulse that sets the scan-armed bit |
| trig_in | input | 1 | Asynchronous external trigger / gate |
| arb_grant | input | 1 | Grant from the priority arbiter |
| cmd_eoq | input | 1 | End-of-queue marker of the head command |
| cmd_pause | input | 1 | Pause marker of the head command |
| tx_done | input | 1 | Link signals the outstanding command completed |
| flag_clr | input | 3 | Per-flag clear pulses |
| irq_en | input | 3 | Per-flag interrupt enables |
| q_status | output | 1 | 0 IDLE, 1 TRIGGERED |
| scan_armed | output | 1 | Scan-start bit |
| xfer_en | output | 1 | Transfer request to the arbiter |
| tx_start | output | 1 | A command is issued this cycle |
| xfer_count | output | CNT_W | Completed transfers since the last end-of-queue |
| flags | output | 3 | Sticky status flags |
| irqs | output | 3 | Interrupt requests |

## Verification
The bench builds the block with CNT_W=4, so the random continuous-software run of several dozen transfers can reach the wrap of the count past 15 between end-of-queue resets. SYNC_STAGES stays at 2. With that setting, waiting four cycles after each trigger change is enough for the gate to settle, which makes the closing and reopening of the gate inside a single held-off transfer reachable with directed steps.

// File: rtl/cq_scan_pkg.sv
package cq_scan_pkg;
  typedef enum logic [2:0] {
    MODE_OFF       = 3'd0,
    MODE_SGL_LVL   = 3'd1,
    MODE_CONT_SW   = 3'd2,
    MODE_CONT_RISE = 3'd3,
    MODE_CONT_FALL = 3'd4,
    MODE_CONT_BOTH = 3'd5
  } mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_TRIG = 1'b1
  } qstat_e;

  localparam int FLAG_PAUSE = 0;
  localparam int FLAG_EOQ   = 1;
  localparam int FLAG_OVR   = 2;
  localparam int NUM_FLAGS  = 3;
endpackage

// File: rtl/cq_trig_sync.sv
module cq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic gate,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg[0] <= 1'b0;
        else        shreg[0] <= trig_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg[i] <= 1'b0;
        else        shreg[i] <= shreg[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= shreg[STAGES-1];
  end

  assign gate = shreg[STAGES-1];
  assign rise = gate & ~prev;
  assign fall = ~gate & prev;
endmodule

// File: rtl/cq_xfer_track.sv
module cq_xfer_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             eoq_in,
  input  logic             pause_in,
  input  logic             done_in,
  output logic             busy,
  output logic             done,
  output logic             eoq_c,
  output logic             pause_c,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign done = done_in & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      eoq_c   <= 1'b0;
      pause_c <= 1'b0;
      count   <= '0;
    end else if (clr) begin
      busy    <= 1'b0;
      eoq_c   <= 1'b0;
      pause_c <= 1'b0;
      count   <= '0;
    end else begin
      if (start) begin
        busy    <= 1'b1;
        eoq_c   <= eoq_in;
        pause_c <= pause_in;
      end else if (done) begin
        busy <= 1'b0;
      end
      if (done) count <= eoq_c ? '0 : count + ONE;
    end
  end
endmodule

// File: rtl/cq_flag_bank.sv
module cq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flag,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
    assign irq[i] = flag[i] & en[i];
  end
endmodule

// File: rtl/cq_scan_ctrl.sv
module cq_scan_ctrl
  import cq_scan_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             scan_start_set,
  input  logic             trig_in,
  input  logic             arb_grant,
  input  logic             cmd_eoq,
  input  logic             cmd_pause,
  input  logic             tx_done,
  input  logic [2:0]       flag_clr,
  input  logic [2:0]       irq_en,
  output logic             q_status,
  output logic             scan_armed,
  output logic             xfer_en,
  output logic             tx_start,
  output logic [CNT_W-1:0] xfer_count,
  output logic [2:0]       flags,
  output logic [2:0]       irqs
);
  mode_e  md;
  qstat_e stat, stat_n;
  logic   armed_n, pend, pend_n;
  logic   gate, rise, fall, edge_hit, off;
  logic   busy, done, eoq_c, pause_c;
  logic [NUM_FLAGS-1:0] fset;

  assign md  = mode_e'(mode);
  assign off = !(md inside {MODE_SGL_LVL, MODE_CONT_SW, MODE_CONT_RISE,
                            MODE_CONT_FALL, MODE_CONT_BOTH});

  cq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .gate(gate), .rise(rise), .fall(fall)
  );

  assign edge_hit = ((md == MODE_CONT_RISE) & rise) |
                    ((md == MODE_CONT_FALL) & fall) |
                    ((md == MODE_CONT_BOTH) & (rise | fall));

  // issue request: triggered, nothing in flight, gate open in level mode
  assign xfer_en  = !off && (stat == ST_TRIG) && !busy &&
                    !((md == MODE_SGL_LVL) && !gate);
  assign tx_start = xfer_en & arb_grant;

  cq_xfer_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(off), .start(tx_start),
    .eoq_in(cmd_eoq), .pause_in(cmd_pause), .done_in(tx_done),
    .busy(busy), .done(done), .eoq_c(eoq_c), .pause_c(pause_c),
    .count(xfer_count)
  );

  always_comb begin
    stat_n  = stat;
    armed_n = scan_armed;
    pend_n  = pend;
    fset    = '0;
    if (off) begin
      stat_n  = ST_IDLE;
      armed_n = 1'b0;
      pend_n  = 1'b0;
    end else begin
      if (scan_start_set) armed_n = 1'b1;
      if (done && eoq_c)  fset[FLAG_EOQ] = 1'b1;
      unique case (md)
        MODE_SGL_LVL: begin
          if (stat == ST_IDLE) begin
            if (scan_armed && gate) stat_n = ST_TRIG;
          end else if (done) begin
            pend_n = 1'b0;
            if (eoq_c) begin
              stat_n  = ST_IDLE;
              armed_n = 1'b0;
            end else if (!gate) begin
              stat_n  = ST_IDLE;
              armed_n = 1'b0;
              fset[FLAG_PAUSE] = 1'b1;
            end
          end else if (!busy) begin
            if (!gate) begin
              stat_n  = ST_IDLE;
              armed_n = 1'b0;
              fset[FLAG_PAUSE] = 1'b1;
            end
          end else begin
            if (fall) pend_n = 1'b1;
            if (pend && rise) begin
              pend_n = 1'b0;
              fset[FLAG_OVR] = 1'b1;
            end
          end
        end
        MODE_CONT_SW: stat_n = ST_TRIG;
        default: begin
          if (edge_hit) begin
            if (stat == ST_IDLE) stat_n = ST_TRIG;
            else                 fset[FLAG_OVR] = 1'b1;
          end
          if (done && (eoq_c || pause_c)) begin
            stat_n = ST_IDLE;
            if (pause_c) fset[FLAG_PAUSE] = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat       <= ST_IDLE;
      scan_armed <= 1'b0;
      pend       <= 1'b0;
    end else begin
      stat       <= stat_n;
      scan_armed <= armed_n;
      pend       <= pend_n;
    end
  end

  assign q_status = (stat == ST_TRIG);

  cq_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(flag_clr),
    .en(irq_en), .flag(flags), .irq(irqs)
  );
endmodule

// File: rtl/cq_scan_chk.sv
module cq_scan_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             scan_start_set,
  input logic             tx_done,
  input logic             q_status,
  input logic             scan_armed,
  input logic             xfer_en,
  input logic             tx_start,
  input logic [CNT_W-1:0] xfer_count
);
  AST_OFF_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> (!q_status && xfer_count == '0 && !scan_armed && !xfer_en)); // R1

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R2

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd1 && mode <= 3'd5 && !tx_done) |=> (xfer_count == $past(xfer_count))); // R2

  AST_LEVEL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !q_status && !scan_armed) |=> !q_status); // R3

  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && q_status && !scan_start_set) |=> (q_status || !scan_armed)); // R5

  AST_SW_NEVER_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && q_status) |=> q_status); // R8
endmodule

bind cq_scan_ctrl cq_scan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .scan_start_set(scan_start_set),
  .tx_done(tx_done), .q_status(q_status), .scan_armed(scan_armed),
  .xfer_en(xfer_en), .tx_start(tx_start), .xfer_count(xfer_count)
);

// File: tb/sim_cq_scan_ctrl.sv
module sim_cq_scan_ctrl;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic          scan_start_set = 1'b0, trig_in = 1'b0, arb_grant = 1'b0;
  logic          cmd_eoq = 1'b0, cmd_pause = 1'b0, tx_done = 1'b0;
  logic [2:0]    flag_clr = 3'd0, irq_en = 3'd0;
  logic          q_status, scan_armed, xfer_en, tx_start;
  logic [CW-1:0] xfer_count;
  logic [2:0]    flags, irqs;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  cq_scan_ctrl #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .scan_start_set(scan_start_set),
    .trig_in(trig_in), .arb_grant(arb_grant), .cmd_eoq(cmd_eoq),
    .cmd_pause(cmd_pause), .tx_done(tx_done), .flag_clr(flag_clr),
    .irq_en(irq_en), .q_status(q_status), .scan_armed(scan_armed),
    .xfer_en(xfer_en), .tx_start(tx_start), .xfer_count(xfer_count),
    .flags(flags), .irqs(irqs)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL R2 watchdog expired: act=%0d exp=<100000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [CW-1:0] next_count(logic [CW-1:0] c, logic eoq);
    return eoq ? '0 : CW'(c + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    scan_start_set = 1'b1; tick(1); scan_start_set = 1'b0; tick(2);
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111; tick(1); flag_clr = 3'b000; tick(1);
  endtask

  task automatic start_xfer(logic e, logic p);
    int w = 0;
    while (!xfer_en && w < 50) begin tick(1); w++; end
    chk("R2 xfer_en before grant", 32'(xfer_en), 32'd1);
    arb_grant = 1'b1; cmd_eoq = e; cmd_pause = p;
    tick(1);
    arb_grant = 1'b0; cmd_eoq = 1'b0; cmd_pause = 1'b0;
  endtask

  task automatic finish_xfer();
    tx_done = 1'b1; tick(1); tx_done = 1'b0;
  endtask

  task automatic do_xfer(logic e, logic p, int lat);
    start_xfer(e, p);
    chk("R2 no request while in flight", 32'(xfer_en), 32'd0);
    tick(lat);
    finish_xfer();
  endtask

  initial begin
    logic [CW-1:0] exp_cnt;
    logic          saw_eoq;
    void'($urandom(32'd20240611));
    tick(3); rst_n = 1'b1; tick(1);
    // reset state
    chk("R1 reset status", 32'(q_status), 0);
    chk("R1 reset count", 32'(xfer_count), 0);
    chk("R2 reset xfer_en", 32'(xfer_en), 0);
    chk("R11 reset flags", 32'(flags), 0);

    // single-scan level: start needs arm and open gate
    mode = 3'd1; trig_in = 1'b1; tick(4);
    chk("R3 gate open but unarmed", 32'(q_status), 0);
    arm();
    chk("R3 armed and gate open", 32'(q_status), 1);
    do_xfer(1'b0, 1'b1, 2);
    chk("R2 count after one", 32'(xfer_count), 1);
    chk("R4 pause ignored status", 32'(q_status), 1);
    chk("R4 pause ignored flag", 32'(flags[0]), 0);
    do_xfer(1'b1, 1'b0, 1);
    chk("R4 eoq stops", 32'(q_status), 0);
    chk("R4 eoq disarms", 32'(scan_armed), 0);
    chk("R4 eoq flag", 32'(flags[1]), 1);
    chk("R2 eoq resets count", 32'(xfer_count), 0);
    clear_flags();
    chk("R11 flags cleared", 32'(flags), 0);

    // gate closes with nothing in flight
    arm();
    do_xfer(1'b0, 1'b0, 0);
    do_xfer(1'b0, 1'b0, 3);
    trig_in = 1'b0; tick(4);
    chk("R5 closed gate idles", 32'(q_status), 0);
    chk("R5 pause flag", 32'(flags[0]), 1);
    chk("R5 disarmed", 32'(scan_armed), 0);
    chk("R5 count kept", 32'(xfer_count), 2);
    trig_in = 1'b1; tick(4);
    chk("R5 restart needs arm", 32'(q_status), 0);
    arm();
    chk("R5 restarted", 32'(q_status), 1);
    chk("R5 resumes at same command", 32'(xfer_count), 2);
    clear_flags();

    // gate closes during a transfer
    start_xfer(1'b0, 1'b0);
    trig_in = 1'b0; tick(5);
    chk("R6 deferred status", 32'(q_status), 1);
    chk("R6 deferred pause flag", 32'(flags[0]), 0);
    finish_xfer();
    chk("R6 count updated", 32'(xfer_count), 3);
    chk("R6 idle after done", 32'(q_status), 0);
    chk("R6 pause flag after done", 32'(flags[0]), 1);
    chk("R6 disarmed", 32'(scan_armed), 0);
    clear_flags();

    // gate closes and reopens within a transfer
    trig_in = 1'b1; tick(4); arm();
    start_xfer(1'b0, 1'b0);
    trig_in = 1'b0; tick(4); trig_in = 1'b1; tick(4);
    chk("R7 overrun flag", 32'(flags[2]), 1);
    chk("R7 status kept", 32'(q_status), 1);
    finish_xfer();
    chk("R7 count", 32'(xfer_count), 4);
    chk("R7 pause flag untouched", 32'(flags[0]), 0);
    chk("R7 continues", 32'(xfer_en), 1);

    // disabled within one clock
    mode = 3'd0; tick(1);
    chk("R1 disabled status", 32'(q_status), 0);
    chk("R1 disabled count", 32'(xfer_count), 0);
    chk("R1 disabled armed", 32'(scan_armed), 0);
    chk("R1 disabled xfer_en", 32'(xfer_en), 0);
    clear_flags();

    // continuous software, random traffic
    mode = 3'd2; tick(2);
    chk("R8 triggered without arm", 32'(q_status), 1);
    exp_cnt = '0; saw_eoq = 1'b0;
    for (int k = 0; k < 60; k++) begin
      logic e, p;
      e = ($urandom % 6) == 0;
      p = $urandom % 2;
      tick($urandom % 3);
      do_xfer(e, p, $urandom % 4);
      exp_cnt = next_count(exp_cnt, e);
      saw_eoq |= e;
      chk("R8 random count", 32'(xfer_count), 32'(exp_cnt));
      chk("R8 never halts", 32'(q_status), 1);
    end
    do_xfer(1'b1, 1'b0, 0);
    chk("R8 eoq resets count", 32'(xfer_count), 0);
    chk("R8 flags eoq only", 32'(flags), 32'b010);
    irq_en = 3'b010; tick(1);
    chk("R11 eoq irq", 32'(irqs), 32'b010);
    flag_clr = 3'b010; tick(1); flag_clr = 3'b000;
    chk("R11 eoq cleared", 32'(flags[1]), 0);
    chk("R11 irq drops", 32'(irqs), 0);

    // continuous rising edge
    mode = 3'd0; trig_in = 1'b0; tick(4);
    mode = 3'd3; tick(2);
    chk("R9 waits for edge", 32'(q_status), 0);
    trig_in = 1'b1; tick(4);
    chk("R9 rising edge triggers", 32'(q_status), 1);
    do_xfer(1'b0, 1'b0, 1);
    chk("R9 plain command continues", 32'(q_status), 1);
    do_xfer(1'b0, 1'b1, 1);
    chk("R9 pause halts", 32'(q_status), 0);
    chk("R9 pause flag", 32'(flags[0]), 1);
    chk("R9 count after pause", 32'(xfer_count), 2);
    trig_in = 1'b0; tick(4);
    chk("R9 falling edge ignored", 32'(q_status), 0);
    trig_in = 1'b1; tick(4);
    chk("R9 rearmed by edge", 32'(q_status), 1);
    chk("R9 count kept", 32'(xfer_count), 2);
    do_xfer(1'b1, 1'b0, 0);
    chk("R9 eoq halts", 32'(q_status), 0);
    chk("R9 eoq flag", 32'(flags[1]), 1);
    clear_flags();

    // continuous falling edge, overrun
    mode = 3'd0; tick(1); mode = 3'd4; tick(2);
    trig_in = 1'b0; tick(4);
    chk("R9 falling edge triggers", 32'(q_status), 1);
    trig_in = 1'b1; tick(4); trig_in = 1'b0; tick(4);
    chk("R10 overrun on second edge", 32'(flags[2]), 1);
    irq_en = 3'b100; tick(1);
    chk("R11 overrun irq", 32'(irqs), 32'b100);

    // either edge
    mode = 3'd0; tick(1); mode = 3'd5; tick(1);
    trig_in = 1'b1; tick(4);
    chk("R9 either edge triggers", 32'(q_status), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule